// File: doc/BRIEF.md
# Far Jump Target Resolver

This unit works out where a far (inter-segment) jump lands in a segmented processor. The front end hands it one request. A request carries the operating mode, the instruction form (pointer held in the instruction, or pointer fetched from memory), whether the indirect operand was a register, the operand size, the target selector and offset, and the current privilege level. For real and virtual-8086 modes the answer comes straight from the selector and offset. For the protected modes the unit fetches descriptors through a simple request/acknowledge read port into the descriptor tables and classifies each one. It then applies the type and privilege rules and follows call gates to their code segment. A 16-byte long-mode gate takes a second read.

The unit reports exactly one result per request. The result is one of three things: a jump (new code selector, base, limit and a 64-bit instruction pointer), a task-switch request naming a task-state selector, or a fault with a vector and an error code. The task switch itself is left to other logic.

Top module: `far_jump_resolver`

## Requirements
- R1: After reset `res_valid` and `rd_req` are low and `req_ready` is high. A request is accepted only while `req_ready` is high. One `res_valid` pulse answers each request.
- R2: Modes are encoded as 0 real, 1 virtual-8086, 2 legacy protected and 3 long 64-bit. In modes 0 and 1 no descriptor is read. The offset is zero-extended from 16 bits when `req_op32` is 0, or from 32 bits when it is 1. An offset above `cur_cs_limit` faults with vector 13, error 0. Otherwise the result is a jump: the selector unchanged, base = selector × 16, limit = `cur_cs_limit`, and the pointer = the offset.
- R3: An indirect request whose operand is a register faults with vector 6, error 0, in every mode. A direct request in mode 3 faults the same way. Both checks come before any other check.
- R4: In modes 2 and 3 the selector is checked in this order, before any read. First, a selector whose bits 15:2 are zero faults with vector 13, error 0. Next, a selector with bit 2 (table select) set while `ldt_null` is high faults with vector 13 and error = selector with bits 1:0 cleared. Last, a descriptor whose 8 bytes run past the chosen table's byte limit raises that same fault.
- R5: The descriptor layout is:

  | Bits | Field |
  |---|---|
  | 15:0 | limit[15:0] |
  | 39:16 | base[23:0] |
  | 43:40 | type |
  | 44 | S |
  | 46:45 | DPL |
  | 47 | present |
  | 51:48 | limit[19:16] |
  | 53 | L |
  | 54 | D |
  | 55 | granularity, which scales the limit to `{limit20, 0xFFF}` |
  | 63:56 | base[31:24] |

  A descriptor with S = 1 and type bit 3 set is code, and type bit 2 marks it conforming. A direct code target jumps to the zero-extended offset, with RPL replaced by the CPL in the new selector. Outside mode 3, an offset above the new limit faults with vector 13, error 0.
- R6: A direct non-conforming code target needs RPL ≤ CPL and DPL = CPL. A direct conforming target needs DPL ≤ CPL. A violation faults with vector 13 and the selector's error code.
- R7: A call gate, task gate or task-state descriptor needs DPL ≥ CPL and DPL ≥ its selector's RPL. Otherwise it faults with vector 13 and the selector's error code.
- R8: A descriptor that passes its type and privilege checks but has present = 0 faults with vector 11 and that selector's error code.
- R9: System types are 1 or 9 (available task state), 5 (task gate), and 4 or 12 (16- or 32-bit call gate). Any other descriptor faults with vector 13 and the selector's error code. In mode 2, a task state gives a task result (kind 1) naming the selector, and a task gate gives a task result naming the selector in its bits 31:16. In mode 3, task states, task gates and 16-bit gates fault with vector 13 and the selector's error code. So does a task state found in the local table, in any protected mode.
- R10: A call gate holds its target selector in bits 31:16 and its offset in bits 15:0 and 63:48. A 16-bit gate uses only bits 15:0. A null gate target faults with vector 13 and the gate's error code. The target is checked as in R4 and then read. It must be code: a conforming target needs DPL ≤ CPL, a non-conforming one DPL = CPL. A bad type or privilege faults with the target's error code, and present = 0 gives vector 11. The jump uses the gate's offset.
- R11: A call gate in mode 3 occupies 16 bytes, and a second read at gate offset + 8 supplies pointer bits 63:32 from its bits 31:0. If the 16 bytes run past the table limit, or bits 44:40 of the second half are non-zero, the unit faults with vector 13 and the gate's error code. The target must have L = 1 and D = 0. The final pointer must be canonical, meaning bits 63:47 are all equal; otherwise the fault is vector 13, error 0.
- R12: `rd_req` stays high with a steady `rd_ldt`/`rd_offset` until `rd_ack`, and `rd_data` is taken in the cycle of `rd_ack`. A direct code target costs one read, a legacy gate two, and a long gate three. The result kinds are 0 jump, 1 task and 2 fault, and vector and error read 0 on a non-fault result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Unit idle, request accepted |
| req_mode | input | 2 | Operating mode |
| req_indirect | input | 1 | Pointer came from memory form |
| req_reg_operand | input | 1 | Indirect form used a register operand |
| req_op32 | input | 1 | 32-bit offset when high, else 16-bit |
| req_sel | input | 16 | Target selector |
| req_offset | input | 32 | Target offset |
| req_cpl | input | 2 | Current privilege level |
| cur_cs_limit | input | 32 | Current code segment limit |
| gdt_limit | input | 16 | Global table byte limit |
| ldt_limit | input | 16 | Local table byte limit |
| ldt_null | input | 1 | Local table selector is null |
| rd_req | output | 1 | Descriptor read request |
| rd_ldt | output | 1 | Read from local table |
| rd_offset | output | 16 | Byte offset into the table |
| rd_ack | input | 1 | Read data valid |
| rd_data | input | 64 | Descriptor quadword |
| res_valid | output | 1 | Result strobe, one cycle |
| res_kind | output | 2 | 0 jump, 1 task, 2 fault |
| res_vector | output | 8 | Fault vector |
| res_err | output | 16 | Fault error code |
| res_cs_sel | output | 16 | New code selector or task selector |
| res_cs_base | output | 32 | New code base |
| res_cs_limit | output | 32 | New code limit |
| res_rip | output | 64 | New instruction pointer |

## Verification
The assertions take it for granted that the table limits, `ldt_null` and `cur_cs_limit` hold still while a request is in flight. They also assume `rd_ack` only comes while `rd_req` is high, and that no new request is offered in the cycle a result is reported. The bench keeps to this. It drives every request from an idle unit and answers reads one cycle after they appear. It also waits for each result before it changes any table or limit.

// File: rtl/fjr_pkg.sv
package fjr_pkg;
  typedef enum logic [1:0] {MODE_REAL = 2'd0, MODE_V86 = 2'd1, MODE_PROT = 2'd2, MODE_LONG = 2'd3} fjr_mode_e;
  typedef enum logic [1:0] {OUT_JUMP = 2'd0, OUT_TASK = 2'd1, OUT_FAULT = 2'd2} fjr_kind_e;
  typedef enum logic [2:0] {CLS_BAD, CLS_CODE, CLS_TSS, CLS_TGATE, CLS_CGATE} fjr_cls_e;
  typedef enum logic [1:0] {S_IDLE, S_DESC, S_UPPER, S_CODE} fjr_state_e;

  localparam logic [7:0] VEC_UD = 8'd6;
  localparam logic [7:0] VEC_NP = 8'd11;
  localparam logic [7:0] VEC_GP = 8'd13;

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] limit;
    fjr_cls_e    cls;
    logic        gate16;
    logic [1:0]  dpl;
    logic        present;
    logic        conforming;
    logic        lbit;
    logic        dbit;
    logic [15:0] tgt_sel;
    logic [31:0] gate_off;
  } fjr_desc_t;

  typedef struct packed {
    fjr_kind_e   kind;
    logic [7:0]  vec;
    logic [15:0] err;
    logic [15:0] sel;
    logic [31:0] base;
    logic [31:0] lim;
    logic [63:0] rip;
  } fjr_res_t;

  function automatic logic [15:0] sel_err(input logic [15:0] s);
    return {s[15:2], 2'b00};
  endfunction

  function automatic fjr_res_t mk_fault(input logic [7:0] v, input logic [15:0] e);
    fjr_res_t r;
    r      = '0;
    r.kind = OUT_FAULT;
    r.vec  = v;
    r.err  = e;
    return r;
  endfunction

  function automatic fjr_res_t mk_jump(input logic [15:0] s, input logic [31:0] b,
                                       input logic [31:0] l, input logic [63:0] ip);
    fjr_res_t r;
    r      = '0;
    r.kind = OUT_JUMP;
    r.sel  = s;
    r.base = b;
    r.lim  = l;
    r.rip  = ip;
    return r;
  endfunction

  function automatic fjr_res_t mk_task(input logic [15:0] s);
    fjr_res_t r;
    r      = '0;
    r.kind = OUT_TASK;
    r.sel  = s;
    return r;
  endfunction
endpackage

// File: rtl/fjr_desc_decode.sv
module fjr_desc_decode
  import fjr_pkg::*;
(
  input  logic [63:0] raw,
  output fjr_desc_t   dsc
);
  logic [19:0] lim20;
  logic [3:0]  typ;

  assign lim20 = {raw[51:48], raw[15:0]};
  assign typ   = raw[43:40];

  always_comb begin
    dsc            = '0;
    dsc.base       = {raw[63:56], raw[39:16]};
    dsc.limit      = raw[55] ? {lim20, 12'hFFF} : {12'h000, lim20};
    dsc.dpl        = raw[46:45];
    dsc.present    = raw[47];
    dsc.conforming = raw[42];
    dsc.lbit       = raw[53];
    dsc.dbit       = raw[54];
    dsc.tgt_sel    = raw[31:16];
    dsc.gate16     = (typ == 4'h4);
    dsc.gate_off   = dsc.gate16 ? {16'h0000, raw[15:0]} : {raw[63:48], raw[15:0]};
    if (raw[44]) begin
      dsc.cls = typ[3] ? CLS_CODE : CLS_BAD;
    end else begin
      case (typ)
        4'h1, 4'h9: dsc.cls = CLS_TSS;
        4'h5:       dsc.cls = CLS_TGATE;
        4'h4, 4'hC: dsc.cls = CLS_CGATE;
        default:    dsc.cls = CLS_BAD;
      endcase
    end
  end
endmodule

// File: rtl/fjr_sel_check.sv
module fjr_sel_check #(
  parameter int SEL_W = 16
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             ldt_null,
  input  logic [SEL_W-1:0] gdt_limit,
  input  logic [SEL_W-1:0] ldt_limit,
  output logic             is_null,
  output logic             ldt_bad,
  output logic             over8,
  output logic             over16
);
  localparam int EXT_W = SEL_W + 1;

  logic [SEL_W-1:0] lim;
  logic [EXT_W-1:0] first_byte;
  logic [EXT_W-1:0] last8;
  logic [EXT_W-1:0] last16;

  assign is_null    = (sel[SEL_W-1:2] == '0);
  assign ldt_bad    = sel[2] & ldt_null;
  assign lim        = sel[2] ? ldt_limit : gdt_limit;
  assign first_byte = {1'b0, sel[SEL_W-1:3], 3'b000};
  assign last8      = first_byte + EXT_W'(7);
  assign last16     = first_byte + EXT_W'(15);
  assign over8      = last8 > {1'b0, lim};
  assign over16     = last16 > {1'b0, lim};
endmodule

// File: rtl/far_jump_resolver.sv
module far_jump_resolver
  import fjr_pkg::*;
#(
  parameter int SEL_W   = 16,
  parameter int OFF_W   = 32,
  parameter int VA_BITS = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_mode,
  input  logic             req_indirect,
  input  logic             req_reg_operand,
  input  logic             req_op32,
  input  logic [SEL_W-1:0] req_sel,
  input  logic [OFF_W-1:0] req_offset,
  input  logic [1:0]       req_cpl,
  input  logic [31:0]      cur_cs_limit,
  input  logic [SEL_W-1:0] gdt_limit,
  input  logic [SEL_W-1:0] ldt_limit,
  input  logic             ldt_null,
  output logic             rd_req,
  output logic             rd_ldt,
  output logic [SEL_W-1:0] rd_offset,
  input  logic             rd_ack,
  input  logic [63:0]      rd_data,
  output logic             res_valid,
  output logic [1:0]       res_kind,
  output logic [7:0]       res_vector,
  output logic [15:0]      res_err,
  output logic [15:0]      res_cs_sel,
  output logic [31:0]      res_cs_base,
  output logic [31:0]      res_cs_limit,
  output logic [63:0]      res_rip
);
  localparam int CAN_W = 64 - VA_BITS + 1;

  function automatic logic canon(input logic [63:0] a);
    logic [CAN_W-1:0] h;
    h = a[63:VA_BITS-1];
    return (&h) | (~|h);
  endfunction

  fjr_state_e       st_q, st_d;
  logic [SEL_W-1:0] sel_q, sel_d, gsel_q, gsel_d;
  logic [31:0]      off_q, off_d;
  logic [63:0]      goff_q, goff_d;
  logic [1:0]       cpl_q, cpl_d;
  logic             long_q, long_d;
  fjr_res_t         res_q, res_d;
  logic             res_v_q, fin;

  fjr_desc_t        dd;
  logic [SEL_W-1:0] outer_sel, inner_sel;
  logic             o_null, o_ldt, o_over8, o_over16;
  logic             i_null, i_ldt, i_over8, i_over16;
  logic [31:0]      off_ext;
  logic             bad_type, tss_in_ldt, outer_priv_ok, inner_priv_ok, code64;

  fjr_desc_decode u_dec (.raw(rd_data), .dsc(dd));

  assign outer_sel = (st_q == S_IDLE) ? req_sel : sel_q;
  assign inner_sel = (st_q == S_DESC) ? dd.tgt_sel : gsel_q;

  fjr_sel_check #(.SEL_W(SEL_W)) u_chk_outer (
    .sel(outer_sel), .ldt_null(ldt_null), .gdt_limit(gdt_limit), .ldt_limit(ldt_limit),
    .is_null(o_null), .ldt_bad(o_ldt), .over8(o_over8), .over16(o_over16));

  fjr_sel_check #(.SEL_W(SEL_W)) u_chk_inner (
    .sel(inner_sel), .ldt_null(ldt_null), .gdt_limit(gdt_limit), .ldt_limit(ldt_limit),
    .is_null(i_null), .ldt_bad(i_ldt), .over8(i_over8), .over16(i_over16));

  assign off_ext  = req_op32 ? 32'(req_offset) : {16'h0000, req_offset[15:0]};
  assign bad_type = (dd.cls == CLS_BAD) ||
                    (long_q && ((dd.cls == CLS_TSS) || (dd.cls == CLS_TGATE) ||
                                ((dd.cls == CLS_CGATE) && dd.gate16)));
  assign tss_in_ldt    = (dd.cls == CLS_TSS) && sel_q[2];
  assign outer_priv_ok = (dd.cls == CLS_CODE) ?
                         (dd.conforming ? (dd.dpl <= cpl_q)
                                        : ((sel_q[1:0] <= cpl_q) && (dd.dpl == cpl_q))) :
                         ((dd.dpl >= cpl_q) && (dd.dpl >= sel_q[1:0]));
  assign inner_priv_ok = dd.conforming ? (dd.dpl <= cpl_q) : (dd.dpl == cpl_q);
  assign code64        = dd.lbit & ~dd.dbit;

  // read port drive
  always_comb begin
    rd_req    = (st_q != S_IDLE);
    rd_ldt    = 1'b0;
    rd_offset = '0;
    case (st_q)
      S_DESC:  begin rd_ldt = sel_q[2];  rd_offset = {sel_q[SEL_W-1:3], 3'b000}; end
      S_UPPER: begin rd_ldt = sel_q[2];  rd_offset = {sel_q[SEL_W-1:3], 3'b000} + SEL_W'(8); end
      S_CODE:  begin rd_ldt = gsel_q[2]; rd_offset = {gsel_q[SEL_W-1:3], 3'b000}; end
      default: ;
    endcase
  end

  // next state
  always_comb begin
    st_d   = st_q;
    sel_d  = sel_q;
    off_d  = off_q;
    cpl_d  = cpl_q;
    long_d = long_q;
    gsel_d = gsel_q;
    goff_d = goff_q;
    fin    = 1'b0;
    res_d  = res_q;
    case (st_q)
      S_IDLE: if (req_valid) begin
        sel_d  = req_sel;
        off_d  = off_ext;
        cpl_d  = req_cpl;
        long_d = (req_mode == MODE_LONG);
        fin    = 1'b1;
        if (req_indirect && req_reg_operand)
          res_d = mk_fault(VEC_UD, 16'h0);
        else if ((req_mode == MODE_LONG) && !req_indirect)
          res_d = mk_fault(VEC_UD, 16'h0);
        else if ((req_mode == MODE_REAL) || (req_mode == MODE_V86)) begin
          if (off_ext > cur_cs_limit) res_d = mk_fault(VEC_GP, 16'h0);
          else res_d = mk_jump(req_sel, {12'h000, req_sel, 4'h0}, cur_cs_limit, {32'h0, off_ext});
        end
        else if (o_null)          res_d = mk_fault(VEC_GP, 16'h0);
        else if (o_ldt || o_over8) res_d = mk_fault(VEC_GP, sel_err(req_sel));
        else begin
          fin  = 1'b0;
          st_d = S_DESC;
        end
      end
      S_DESC: if (rd_ack) begin
        st_d = S_IDLE;
        fin  = 1'b1;
        if (bad_type || tss_in_ldt || !outer_priv_ok)
          res_d = mk_fault(VEC_GP, sel_err(sel_q));
        else if (!dd.present)
          res_d = mk_fault(VEC_NP, sel_err(sel_q));
        else begin
          case (dd.cls)
            CLS_CODE: begin
              if (!long_q && (off_q > dd.limit)) res_d = mk_fault(VEC_GP, 16'h0);
              else res_d = mk_jump({sel_q[SEL_W-1:2], cpl_q}, dd.base, dd.limit, {32'h0, off_q});
            end
            CLS_TSS: res_d = mk_task(sel_q);
            CLS_TGATE: begin
              if (i_null) res_d = mk_fault(VEC_GP, sel_err(sel_q));
              else        res_d = mk_task(dd.tgt_sel);
            end
            default: begin
              gsel_d = dd.tgt_sel;
              goff_d = {32'h0, dd.gate_off};
              if (i_null)                 res_d = mk_fault(VEC_GP, sel_err(sel_q));
              else if (long_q && o_over16) res_d = mk_fault(VEC_GP, sel_err(sel_q));
              else if (long_q) begin fin = 1'b0; st_d = S_UPPER; end
              else if (i_ldt || i_over8)  res_d = mk_fault(VEC_GP, sel_err(dd.tgt_sel));
              else begin fin = 1'b0; st_d = S_CODE; end
            end
          endcase
        end
      end
      S_UPPER: if (rd_ack) begin
        goff_d = {rd_data[31:0], goff_q[31:0]};
        st_d   = S_IDLE;
        fin    = 1'b1;
        if (rd_data[44:40] != 5'd0)   res_d = mk_fault(VEC_GP, sel_err(sel_q));
        else if (i_ldt || i_over8)    res_d = mk_fault(VEC_GP, sel_err(gsel_q));
        else begin fin = 1'b0; st_d = S_CODE; end
      end
      S_CODE: if (rd_ack) begin
        st_d = S_IDLE;
        fin  = 1'b1;
        if ((dd.cls != CLS_CODE) || (long_q && !code64) || !inner_priv_ok)
          res_d = mk_fault(VEC_GP, sel_err(gsel_q));
        else if (!dd.present)
          res_d = mk_fault(VEC_NP, sel_err(gsel_q));
        else if (long_q ? !canon(goff_q) : (goff_q > {32'h0, dd.limit}))
          res_d = mk_fault(VEC_GP, 16'h0);
        else
          res_d = mk_jump({gsel_q[SEL_W-1:2], cpl_q}, dd.base, dd.limit, goff_q);
      end
      default: st_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      sel_q   <= '0;
      off_q   <= '0;
      cpl_q   <= '0;
      long_q  <= 1'b0;
      gsel_q  <= '0;
      goff_q  <= '0;
      res_q   <= '0;
      res_v_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      sel_q   <= sel_d;
      off_q   <= off_d;
      cpl_q   <= cpl_d;
      long_q  <= long_d;
      gsel_q  <= gsel_d;
      goff_q  <= goff_d;
      res_v_q <= fin;
      if (fin) res_q <= res_d;
    end
  end

  assign req_ready    = (st_q == S_IDLE);
  assign res_valid    = res_v_q;
  assign res_kind     = res_q.kind;
  assign res_vector   = res_q.vec;
  assign res_err      = res_q.err;
  assign res_cs_sel   = res_q.sel;
  assign res_cs_base  = res_q.base;
  assign res_cs_limit = res_q.lim;
  assign res_rip      = res_q.rip;

  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_offset) && $stable(rd_ldt)));

  // R12
  nonfault_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_kind != OUT_FAULT)) |-> ((res_vector == 8'd0) && (res_err == 16'd0)));

  // R9
  no_long_task_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_kind == OUT_TASK)) |-> !long_q);

  // R5
  within_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_kind == OUT_JUMP) && !long_q) |-> (res_rip <= {32'h0, res_cs_limit}));

  // R11
  canonical_rip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_kind == OUT_JUMP) && long_q) |-> canon(res_rip));

  // R8
  np_selector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_vector == VEC_NP)) |-> (res_err != 16'd0));
endmodule

// File: tb/far_jump_resolver_tb_top.sv
module far_jump_resolver_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_indirect, req_reg_operand, req_op32;
  logic [1:0]  req_mode, req_cpl;
  logic [15:0] req_sel;
  logic [31:0] req_offset, cur_cs_limit;
  logic [15:0] gdt_limit, ldt_limit;
  logic        ldt_null;
  logic        rd_req, rd_ldt, rd_ack;
  logic [15:0] rd_offset;
  logic [63:0] rd_data;
  logic        res_valid;
  logic [1:0]  res_kind;
  logic [7:0]  res_vector;
  logic [15:0] res_err, res_cs_sel;
  logic [31:0] res_cs_base, res_cs_limit;
  logic [63:0] res_rip;

  int checks = 0;
  int errors = 0;
  int reads  = 0;
  logic [63:0] gdt [20];
  logic [63:0] ldt [4];

  far_jump_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_indirect(req_indirect), .req_reg_operand(req_reg_operand),
    .req_op32(req_op32), .req_sel(req_sel), .req_offset(req_offset), .req_cpl(req_cpl),
    .cur_cs_limit(cur_cs_limit), .gdt_limit(gdt_limit), .ldt_limit(ldt_limit),
    .ldt_null(ldt_null), .rd_req(rd_req), .rd_ldt(rd_ldt), .rd_offset(rd_offset),
    .rd_ack(rd_ack), .rd_data(rd_data), .res_valid(res_valid), .res_kind(res_kind),
    .res_vector(res_vector), .res_err(res_err), .res_cs_sel(res_cs_sel),
    .res_cs_base(res_cs_base), .res_cs_limit(res_cs_limit), .res_rip(res_rip));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // descriptor memory answering one cycle after a request appears
  initial begin
    rd_ack  = 1'b0;
    rd_data = '0;
    forever begin
      @(negedge clk);
      if (rd_req && !rd_ack) begin
        rd_ack = 1'b1;
        reads++;
        if (rd_ldt) rd_data = (rd_offset[15:3] < 4)  ? ldt[rd_offset[4:3]] : 64'h0;
        else        rd_data = (rd_offset[15:3] < 20) ? gdt[rd_offset[7:3]] : 64'h0;
      end else begin
        rd_ack = 1'b0;
      end
    end
  end

  function automatic logic [63:0] code_d(input logic [31:0] base, input logic [19:0] lim,
      input logic g, input logic [1:0] dpl, input logic conf, input logic p,
      input logic l, input logic d);
    logic [63:0] r;
    r = '0;
    r[15:0] = lim[15:0];   r[39:16] = base[23:0];
    r[43:40] = {1'b1, conf, 2'b10}; r[44] = 1'b1;
    r[46:45] = dpl; r[47] = p; r[51:48] = lim[19:16];
    r[53] = l; r[54] = d; r[55] = g; r[63:56] = base[31:24];
    return r;
  endfunction

  function automatic logic [63:0] sys_d(input logic [3:0] t, input logic [1:0] dpl,
      input logic [15:0] s, input logic [31:0] off);
    logic [63:0] r;
    r = '0;
    r[15:0] = off[15:0]; r[31:16] = s; r[43:40] = t;
    r[46:45] = dpl; r[47] = 1'b1; r[63:48] = off[31:16];
    return r;
  endfunction

  function automatic logic [63:0] hi_d(input logic [31:0] up, input logic [4:0] ext);
    logic [63:0] r;
    r = '0;
    r[31:0] = up; r[44:40] = ext;
    return r;
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] m, input logic ind, input logic rop, input logic o32,
                     input logic [15:0] s, input logic [31:0] o, input logic [1:0] c, input string tag);
    int waits;
    @(negedge clk);
    req_mode = m; req_indirect = ind; req_reg_operand = rop; req_op32 = o32;
    req_sel = s; req_offset = o; req_cpl = c; req_valid = 1'b1;
    reads = 0;
    @(negedge clk);
    req_valid = 1'b0;
    waits = 0;
    while (!res_valid && waits < 64) begin
      @(negedge clk);
      waits++;
    end
    chk(tag, "result strobe", {63'h0, res_valid}, 64'h1);
  endtask

  task automatic exp_jump(input string tag, input logic [15:0] s, input logic [31:0] b,
                          input logic [31:0] l, input logic [63:0] ip);
    chk(tag, "kind", {62'h0, res_kind}, 64'd0);
    chk(tag, "sel", {48'h0, res_cs_sel}, {48'h0, s});
    chk(tag, "base", {32'h0, res_cs_base}, {32'h0, b});
    chk(tag, "limit", {32'h0, res_cs_limit}, {32'h0, l});
    chk(tag, "rip", res_rip, ip);
  endtask

  task automatic exp_fault(input string tag, input logic [7:0] v, input logic [15:0] e);
    chk(tag, "kind", {62'h0, res_kind}, 64'd2);
    chk(tag, "vector", {56'h0, res_vector}, {56'h0, v});
    chk(tag, "error", {48'h0, res_err}, {48'h0, e});
  endtask

  task automatic exp_task(input string tag, input logic [15:0] s);
    chk(tag, "kind", {62'h0, res_kind}, 64'd1);
    chk(tag, "sel", {48'h0, res_cs_sel}, {48'h0, s});
  endtask

  task automatic t_reset();
    chk("R1", "res_valid", {63'h0, res_valid}, 64'h0);
    chk("R1", "rd_req", {63'h0, rd_req}, 64'h0);
    chk("R1", "ready", {63'h0, req_ready}, 64'h1);
  endtask

  task automatic t_real();
    run(2'd0, 1'b0, 1'b0, 1'b0, 16'h1234, 32'h0000_0100, 2'd0, "R2");
    exp_jump("R2", 16'h1234, 32'h0001_2340, 32'h0000_FFFF, 64'h100);
    chk("R12", "reads", reads, 0);
    run(2'd1, 1'b1, 1'b0, 1'b1, 16'h0040, 32'h0001_0000, 2'd3, "R2");
    exp_fault("R2", 8'd13, 16'h0);
    run(2'd1, 1'b0, 1'b0, 1'b0, 16'h0040, 32'h0001_0005, 2'd3, "R2");
    exp_jump("R2", 16'h0040, 32'h0000_0400, 32'h0000_FFFF, 64'h5);
  endtask

  task automatic t_undef();
    run(2'd2, 1'b1, 1'b1, 1'b1, 16'h0008, 32'h0, 2'd0, "R3");
    exp_fault("R3", 8'd6, 16'h0);
    run(2'd3, 1'b0, 1'b0, 1'b1, 16'h0000, 32'h0, 2'd0, "R3");
    exp_fault("R3", 8'd6, 16'h0);
  endtask

  task automatic t_direct_code();
    run(2'd2, 1'b0, 1'b0, 1'b1, 16'h0008, 32'h0000_FFF0, 2'd0, "R5");
    exp_jump("R5", 16'h0008, 32'h0010_0000, 32'h0000_FFFF, 64'hFFF0);
    chk("R12", "reads", reads, 1);
    run(2'd2, 1'b0, 1'b0, 1'b1, 16'h0008, 32'h0001_0000, 2'd0, "R5");
    exp_fault("R5", 8'd13, 16'h0);
    run(2'd2, 1'b1, 1'b0, 1'b1, 16'h0014, 32'h0000_0010, 2'd0, "R5");
    exp_jump("R5", 16'h0014, 32'h0004_0000, 32'h0000_FFFF, 64'h10);
  endtask

  task automatic t_code_priv();
    run(2'd2, 1'b0, 1'b0, 1'b1, 16'h0013, 32'h8000_0000, 2'd3, "R6");
    exp_jump("R6", 16'h0013, 32'h0020_0000, 32'hFFFF_FFFF, 64'h8000_0000);
    run(2'd2, 1'b0, 1'b0, 1'b1, 16'h0018, 32'h0, 2'd0, "R6");
    exp_fault("R6", 8'd13, 16'h0018);
    run(2'd2, 1'b0, 1'b0, 1'b1, 16'h000B, 32'h0, 2'd0, "R6");
    exp_fault("R6", 8'd13, 16'h0008);
  endtask

  task automatic t_sel_faults();
    run(2'd2, 1'b0, 1'b0, 1'b1, 16'h0003, 32'h0, 2'd0, "R4");
    exp_fault("R4", 8'd13, 16'h0);
    run(2'd2, 1'b0, 1'b0, 1'b1, 16'h00A0, 32'h0, 2'd0, "R4");
    exp_fault("R4", 8'd13, 16'h00A0);
    ldt_null = 1'b1;
    run(2'd2, 1'b0, 1'b0, 1'b1, 16'h0014, 32'h0, 2'd0, "R4");
    exp_fault("R4", 8'd13, 16'h0014);
    ldt_null = 1'b0;
    run(2'd2, 1'b0, 1'b0, 1'b1, 16'h001C, 32'h0, 2'd0, "R9");
    exp_fault("R9", 8'd13, 16'h001C);
  endtask

  task automatic t_not_present();
    run(2'd2, 1'b0, 1'b0, 1'b1, 16'h0020, 32'h0, 2'd0, "R8");
    exp_fault("R8", 8'd11, 16'h0020);
  endtask

  task automatic t_task();
    run(2'd2, 1'b0, 1'b0, 1'b1, 16'h0030, 32'h0, 2'd0, "R9");
    exp_task("R9", 16'h0030);
    run(2'd2, 1'b0, 1'b0, 1'b1, 16'h003B, 32'h0, 2'd3, "R9");
    exp_task("R9", 16'h0030);
    run(2'd3, 1'b1, 1'b0, 1'b1, 16'h0030, 32'h0, 2'd0, "R9");
    exp_fault("R9", 8'd13, 16'h0030);
    run(2'd2, 1'b0, 1'b0, 1'b1, 16'h000C, 32'h0, 2'd0, "R9");
    exp_fault("R9", 8'd13, 16'h000C);
  endtask

  task automatic t_gate_priv();
    run(2'd2, 1'b0, 1'b0, 1'b1, 16'h0004, 32'h0, 2'd3, "R7");
    exp_fault("R7", 8'd13, 16'h0004);
    run(2'd2, 1'b0, 1'b0, 1'b1, 16'h0032, 32'h0, 2'd0, "R7");
    exp_fault("R7", 8'd13, 16'h0030);
  endtask

  task automatic t_gate_legacy();
    run(2'd2, 1'b0, 1'b0, 1'b1, 16'h0040, 32'h0, 2'd0, "R10");
    exp_jump("R10", 16'h0008, 32'h0010_0000, 32'h0000_FFFF, 64'h1234);
    chk("R12", "reads", reads, 2);
    run(2'd2, 1'b0, 1'b0, 1'b1, 16'h0080, 32'h0, 2'd0, "R10");
    exp_fault("R10", 8'd13, 16'h0080);
  endtask

  task automatic t_gate_long();
    run(2'd3, 1'b1, 1'b0, 1'b1, 16'h0050, 32'h0, 2'd0, "R11");
    exp_jump("R11", 16'h0028, 32'h0, 32'hFFFF_FFFF, 64'h0000_7FFF_89AB_CDEF);
    chk("R12", "reads", reads, 3);
    run(2'd3, 1'b1, 1'b0, 1'b1, 16'h0060, 32'h0, 2'd0, "R11");
    exp_fault("R11", 8'd13, 16'h0060);
    run(2'd3, 1'b1, 1'b0, 1'b1, 16'h0070, 32'h0, 2'd0, "R11");
    exp_fault("R11", 8'd13, 16'h0000);
    run(2'd3, 1'b1, 1'b0, 1'b1, 16'h0040, 32'h0, 2'd0, "R11");
    exp_fault("R11", 8'd13, 16'h0008);
    run(2'd3, 1'b1, 1'b0, 1'b1, 16'h0098, 32'h0, 2'd0, "R11");
    exp_fault("R11", 8'd13, 16'h0098);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20; i++) gdt[i] = '0;
    gdt[1]  = code_d(32'h0010_0000, 20'h0FFFF, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1);
    gdt[2]  = code_d(32'h0020_0000, 20'hFFFFF, 1'b1, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1);
    gdt[3]  = code_d(32'h0000_3000, 20'h00FFF, 1'b0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1);
    gdt[4]  = code_d(32'h0000_0000, 20'h0FFFF, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    gdt[5]  = code_d(32'h0000_0000, 20'hFFFFF, 1'b1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0);
    gdt[6]  = sys_d(4'h9, 2'd1, 16'h0000, 32'h0);
    gdt[7]  = sys_d(4'h5, 2'd3, 16'h0030, 32'h0);
    gdt[8]  = sys_d(4'hC, 2'd3, 16'h0008, 32'h0000_1234);
    gdt[9]  = hi_d(32'h0, 5'd0);
    gdt[10] = sys_d(4'hC, 2'd3, 16'h0028, 32'h89AB_CDEF);
    gdt[11] = hi_d(32'h0000_7FFF, 5'd0);
    gdt[12] = sys_d(4'hC, 2'd3, 16'h0028, 32'h0);
    gdt[13] = hi_d(32'h0, 5'd1);
    gdt[14] = sys_d(4'hC, 2'd3, 16'h0028, 32'h0);
    gdt[15] = hi_d(32'h0000_8000, 5'd0);
    gdt[16] = sys_d(4'hC, 2'd3, 16'h0000, 32'h0);
    gdt[19] = sys_d(4'hC, 2'd3, 16'h0028, 32'h0);
    ldt[0]  = sys_d(4'hC, 2'd0, 16'h0008, 32'h0);
    ldt[1]  = sys_d(4'h9, 2'd0, 16'h0000, 32'h0);
    ldt[2]  = code_d(32'h0004_0000, 20'h0FFFF, 1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1);
    ldt[3]  = 64'h0000_9200_0000_FFFF;
    rst_n = 1'b0; req_valid = 1'b0; req_mode = 2'd0; req_indirect = 1'b0;
    req_reg_operand = 1'b0; req_op32 = 1'b0; req_sel = '0; req_offset = '0; req_cpl = '0;
    cur_cs_limit = 32'h0000_FFFF; gdt_limit = 16'h009F; ldt_limit = 16'h001F; ldt_null = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_real();
    t_undef();
    t_direct_code();
    t_code_priv();
    t_sel_faults();
    t_not_present();
    t_task();
    t_gate_priv();
    t_gate_legacy();
    t_gate_long();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule